// File: doc/BRIEF.md
# Vectored Interrupt Controller, 64 Sources

This block gathers up to 64 active-low interrupt request lines into one CPU interrupt. Each line reaches a pending bit and a mask bit. These bits sit in two 32-bit words, named high and low. The assignment of source numbers to word and bit is fixed and is deliberately not linear. Software therefore keeps a lookup table with the same assignment.

A small register bus gives access to the two mask words, the two pending words, a sense-selection word, two priority-grouping words and a read-only vector word. Pending words are cleared by writing ones.

The interrupt output is high while any unmasked source is pending. The vector word names the lowest-numbered unmasked pending source in its top six bits, and a value of 0 means idle. Sources 19..25 are external lines and 48..63 are port lines. Both groups have a per-source edge or level option. All other sources are internal and always level sensitive.

Top module: `vic_top`

## Requirements
- R1: Source to (word, bit) mapping. Sources 1..15 go to the low word, bit 16-s. Sources 16..18 go to the high word, bit 18-s. Sources 19..30 go to the high word, bit 33-s. Sources 32..47 go to the low word, bit 63-s. Sources 48..63 go to the high word, bit s-32. Sources 0 and 31 are reserved and never set any pending bit.
- R2: Mask words are read/write at address 0 (high) and 1 (low). A mask bit of 1 enables its source. Both words reset to 0, so every source is masked after reset.
- R3: Pending words are at address 2 (high) and 3 (low). For an edge-detected source, writing 1 to its pending bit clears it, and writing 0 leaves it unchanged. If a detected edge and a clear fall in the same cycle, the pending bit ends up set.
- R4: A level-detected source's pending bit equals the inverted input one cycle later. Writes to that bit have no effect.
- R5: External sources 19..25 take their sense bit from the address-5 word at the same position as their pending bit. A value of 1 gives falling-edge detection: the pending bit latches on the falling edge and does not re-trigger while the line stays low. A value of 0 gives active-low level detection.
- R6: Port sources 48..63 take their sense bit from the address-5 word at the same position as their pending bit. A value of 1 gives falling-edge-only detection. A value of 0 latches pending on both edges.
- R7: In the sense word only bits 8..14 and 16..31 are writable. All other bits read 0, and the word resets to 0.
- R8: The vector word is at address 4. Bits [31:26] hold the lowest-numbered source that is both pending and unmasked, and all other bits are 0. A value of 0 means none. Writes to address 4 are ignored.
- R9: irq_o is high exactly when some source is both pending and unmasked.
- R10: Addresses 6 and 7 hold read/write priority-grouping words that reset to 0x05309770 and have no effect on the vector.
- R11: bus_rdata_o shows the register selected by bus_addr_i in the same cycle, and bus writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ni | input | 64 | Interrupt request lines, active low, indexed by source number |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable, qualified by bus_req_i |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt to the CPU |

## Verification
An input line changed in one cycle shows in the pending words, the vector and irq_o after the next rising edge. A bus write also takes effect at the next rising edge, after which all outputs that depend on it have settled. The bench changes inputs on falling edges and reads back only at the following falling edge, one rising edge later. Reads are combinational, so each read is sampled one time step after the address is set, well away from any clock edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NUM_SRC = 64;
  localparam int unsigned DW      = 32;
  localparam int unsigned AW      = 3;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  typedef enum logic [1:0] {SRC_NONE, SRC_LEVEL, SRC_EXT, SRC_PORT} src_kind_e;

  typedef enum logic [AW-1:0] {
    REG_MASK_HI = 3'd0,
    REG_MASK_LO = 3'd1,
    REG_PEND_HI = 3'd2,
    REG_PEND_LO = 3'd3,
    REG_VEC     = 3'd4,
    REG_SENSE   = 3'd5,
    REG_PRIO_HI = 3'd6,
    REG_PRIO_LO = 3'd7
  } reg_addr_e;

  function automatic src_kind_e src_kind(input int s);
    if (s == 0 || s == 31) return SRC_NONE;
    if (s >= 19 && s <= 25) return SRC_EXT;
    if (s >= 48) return SRC_PORT;
    return SRC_LEVEL;
  endfunction

  // 16..31 and 48..63 sit in the high word
  function automatic bit src_in_hi(input int s);
    return ((s / 16) % 2) == 1;
  endfunction

  function automatic int src_bit(input int s);
    if (s == 0)  return 0;
    if (s < 16)  return 16 - s;
    if (s < 19)  return 18 - s;
    if (s < 32)  return 33 - s;
    if (s < 48)  return 63 - s;
    return s - 32;
  endfunction

  function automatic logic [DW-1:0] sense_wmask();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_kind(s) == SRC_EXT || src_kind(s) == SRC_PORT) m[src_bit(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell
  import vic_pkg::*;
#(
  parameter src_kind_e KIND = SRC_LEVEL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_ni,
  input  logic edge_sel_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, fall, set_ev, lvl_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= src_ni;
  end

  assign fall = prev_q & ~src_ni;

  if (KIND == SRC_EXT) begin : g_ext
    logic unused_clr;
    assign unused_clr = 1'b0;
    assign lvl_mode   = ~edge_sel_i;
    assign set_ev     = fall;
  end else if (KIND == SRC_PORT) begin : g_port
    logic rise;
    assign rise     = ~prev_q & src_ni;
    assign lvl_mode = 1'b0;
    assign set_ev   = fall | (rise & ~edge_sel_i);
  end else begin : g_lvl
    logic unused_in;
    assign unused_in = edge_sel_i ^ fall;
    assign lvl_mode  = 1'b1;
    assign set_ev    = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (lvl_mode) pend_q <= ~src_ni;
    else if (set_ev)   pend_q <= 1'b1;
    else if (clr_i)    pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R4: level pending tracks the inverted line, writes ignored
  a_r4_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_mode |=> (pend_q == ~$past(src_ni)));

  // R3: edge pending holds until cleared
  a_r3_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode && pend_q && !clr_i) |=> (pend_q || lvl_mode));

  // R3: set beats clear
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode && set_ev) |=> (pend_q || lvl_mode));
endmodule

// File: rtl/vic_first_one.sv
module vic_first_one #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter logic [31:0] PRIO_RESET = 32'h0530_9770
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               irq_o
);
  localparam logic [DW-1:0] SENSE_WMASK = sense_wmask();
  localparam int unsigned   VEC_LSB     = DW - IDX_W;

  logic [DW-1:0] mask_hi_q, mask_lo_q, sense_q, prio_hi_q, prio_lo_q;
  logic [DW-1:0] pend_hi, pend_lo, clr_hi, clr_lo, vec_word;
  logic [NUM_SRC-1:0] pend_src, mask_src, clr_src, sel_src, req_vec;
  logic [IDX_W-1:0] win_idx;
  logic win_found, wr_en;

  assign wr_en = bus_req_i & bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      sense_q   <= '0;
      prio_hi_q <= PRIO_RESET;
      prio_lo_q <= PRIO_RESET;
    end else if (wr_en) begin
      case (bus_addr_i)
        REG_MASK_HI: mask_hi_q <= bus_wdata_i;
        REG_MASK_LO: mask_lo_q <= bus_wdata_i;
        REG_SENSE:   sense_q   <= bus_wdata_i & SENSE_WMASK;
        REG_PRIO_HI: prio_hi_q <= bus_wdata_i;
        REG_PRIO_LO: prio_lo_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_hi = (wr_en && bus_addr_i == REG_PEND_HI) ? bus_wdata_i : '0;
  assign clr_lo = (wr_en && bus_addr_i == REG_PEND_LO) ? bus_wdata_i : '0;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam src_kind_e K  = src_kind(s);
    localparam int        B  = src_bit(s);
    localparam bit        HI = src_in_hi(s);
    if (K == SRC_NONE) begin : g_none
      logic unused_in;
      assign unused_in   = src_ni[s];
      assign pend_src[s] = 1'b0;
      assign mask_src[s] = 1'b0;
      assign clr_src[s]  = 1'b0;
      assign sel_src[s]  = 1'b0;
    end else begin : g_cell
      assign mask_src[s] = HI ? mask_hi_q[B] : mask_lo_q[B];
      assign clr_src[s]  = HI ? clr_hi[B] : clr_lo[B];
      assign sel_src[s]  = sense_q[B];
      vic_src_cell #(.KIND(K)) u_cell (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_ni     (src_ni[s]),
        .edge_sel_i (sel_src[s]),
        .clr_i      (clr_src[s]),
        .pend_o     (pend_src[s])
      );
    end
  end

  logic unused_clr;
  assign unused_clr = ^{clr_hi, clr_lo, clr_src, sel_src};

  always_comb begin
    pend_hi = '0;
    pend_lo = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_kind(s) != SRC_NONE) begin
        if (src_in_hi(s)) pend_hi[src_bit(s)] = pend_src[s];
        else              pend_lo[src_bit(s)] = pend_src[s];
      end
    end
  end

  assign req_vec = pend_src & mask_src;
  assign irq_o   = |req_vec;

  vic_first_one #(.W(NUM_SRC)) u_pick (
    .vec_i   (req_vec),
    .idx_o   (win_idx),
    .found_o (win_found)
  );

  assign vec_word = win_found ? {win_idx, {VEC_LSB{1'b0}}} : '0;

  always_comb begin
    case (bus_addr_i)
      REG_MASK_HI: bus_rdata_o = mask_hi_q;
      REG_MASK_LO: bus_rdata_o = mask_lo_q;
      REG_PEND_HI: bus_rdata_o = pend_hi;
      REG_PEND_LO: bus_rdata_o = pend_lo;
      REG_VEC:     bus_rdata_o = vec_word;
      REG_SENSE:   bus_rdata_o = sense_q;
      REG_PRIO_HI: bus_rdata_o = prio_hi_q;
      default:     bus_rdata_o = prio_lo_q;
    endcase
  end

  // R9: interrupt line agrees with encoder outcome
  a_r9_irq_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (win_idx != '0));

  // R8: winner is requesting and nothing lower requests
  a_r8_winner_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_found |-> req_vec[win_idx]);
  a_r8_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_found |-> ((req_vec & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0));

  // R10: grouping words change only on their own write
  a_r10_prio_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && bus_addr_i == REG_PRIO_HI) |=> $stable(prio_hi_q));

  // R7: non-writable sense bits stay clear
  a_r7_sense_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ((sense_q & ~SENSE_WMASK) == '0));
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vic_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_ni(src_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // 0 none, 1 internal level, 2 external, 3 port
  function automatic int ref_kind(input int s);
    if (s == 0 || s == 31) return 0;
    if (s >= 19 && s <= 25) return 2;
    if (s >= 48) return 3;
    return 1;
  endfunction
  function automatic bit ref_hi(input int s);
    return (s % 32) >= 16;
  endfunction
  function automatic int ref_bit(input int s);
    if (s < 16) return (s == 0) ? 0 : 16 - s;
    if (s < 19) return 18 - s;
    if (s < 32) return 33 - s;
    if (s < 48) return 63 - s;
    return s - 32;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, eh, el;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state: R2 R7 R8 R9 R10
    bus_rd(0, d); chk("R2 reset mask hi", d, 0);
    bus_rd(1, d); chk("R2 reset mask lo", d, 0);
    bus_rd(2, d); chk("R3 reset pend hi", d, 0);
    bus_rd(3, d); chk("R3 reset pend lo", d, 0);
    bus_rd(4, d); chk("R8 reset vector", d, 0);
    bus_rd(5, d); chk("R7 reset sense", d, 0);
    bus_rd(6, d); chk("R10 reset prio hi", d, 32'h05309770);
    bus_rd(7, d); chk("R10 reset prio lo", d, 32'h05309770);
    chk("R9 reset irq", irq, 0);

    // R2 R11 mask readback
    bus_wr(0, 32'hdeadbeef); bus_rd(0, d); chk("R2 R11 mask hi rw", d, 32'hdeadbeef);
    bus_wr(1, 32'h12345678); bus_rd(1, d); chk("R2 R11 mask lo rw", d, 32'h12345678);
    bus_wr(0, 0); bus_wr(1, 0);

    // R1 sweep of all sources with default senses
    for (int s = 0; s < 64; s++) begin
      int k, b;
      bit hi;
      k = ref_kind(s); b = ref_bit(s); hi = ref_hi(s);
      src_n[s] = 1'b0;
      tick();
      eh = (k != 0 && hi)  ? (32'd1 << b) : 0;
      el = (k != 0 && !hi) ? (32'd1 << b) : 0;
      bus_rd(2, d); chk($sformatf("R1 map src %0d hi", s), d, eh);
      bus_rd(3, d); chk($sformatf("R1 map src %0d lo", s), d, el);
      bus_rd(4, d); chk($sformatf("R2 masked vec src %0d", s), d, 0);
      chk($sformatf("R2 masked irq src %0d", s), irq, 0);
      if (k != 0) begin
        bus_wr(hi ? 3'd0 : 3'd1, 32'd1 << b);
        bus_rd(4, d); chk($sformatf("R8 vector src %0d", s), d, 32'(s) << 26);
        chk($sformatf("R9 irq src %0d", s), irq, 1);
      end
      src_n[s] = 1'b1;
      tick();
      bus_rd(hi ? 3'd2 : 3'd3, d);
      // level kinds release, port both-edge keeps pending
      chk($sformatf("R4 R6 release src %0d", s), d, (k == 3) ? (32'd1 << b) : 0);
      bus_wr(2, '1); bus_wr(3, '1);
      bus_rd(2, d); chk($sformatf("R3 clear hi src %0d", s), d, 0);
      bus_rd(3, d); chk($sformatf("R3 clear lo src %0d", s), d, 0);
      bus_wr(0, 0); bus_wr(1, 0);
    end

    // R4 level source 5 (low word bit 11) not cleared while asserted
    src_n[5] = 1'b0; tick();
    bus_wr(3, '1);
    bus_rd(3, d); chk("R4 level held", d, 32'h800);
    src_n[5] = 1'b1; tick();
    bus_rd(3, d); chk("R4 level release", d, 0);

    // R3 selective clear, port 50 (high bit 18)
    src_n[50] = 1'b0; tick(); src_n[50] = 1'b1; tick();
    bus_wr(2, ~(32'd1 << 18));
    bus_rd(2, d); chk("R3 write zero keeps", d, 32'd1 << 18);
    bus_wr(2, 32'd1 << 18);
    bus_rd(2, d); chk("R3 write one clears", d, 0);

    // R3 set beats clear, port 49 (high bit 17)
    src_n[49] = 1'b0; tick();
    @(negedge clk);
    src_n[49] = 1'b1; req = 1'b1; we = 1'b1; addr = 3'd2; wdata = 32'd1 << 17;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    bus_rd(2, d); chk("R3 set wins", d, 32'd1 << 17);
    bus_wr(2, '1);
    bus_rd(2, d); chk("R3 cleared after", d, 0);

    // R5 external 20 (high bit 13) falling edge
    bus_wr(5, 32'd1 << 13);
    src_n[20] = 1'b0; tick(); src_n[20] = 1'b1; tick();
    bus_rd(2, d); chk("R5 edge latched", d, 32'd1 << 13);
    bus_wr(2, 32'd1 << 13);
    bus_rd(2, d); chk("R5 edge cleared", d, 0);
    src_n[20] = 1'b0; tick();
    bus_rd(2, d); chk("R5 edge while low", d, 32'd1 << 13);
    bus_wr(2, 32'd1 << 13);
    bus_rd(2, d); chk("R5 no retrigger", d, 0);
    src_n[20] = 1'b1; tick();
    bus_rd(2, d); chk("R5 rise ignored", d, 0);
    bus_wr(5, 0);

    // R6 port 55 (high bit 23) falling only
    bus_wr(5, 32'd1 << 23);
    src_n[55] = 1'b0; tick();
    bus_rd(2, d); chk("R6 fall latched", d, 32'd1 << 23);
    bus_wr(2, 32'd1 << 23);
    src_n[55] = 1'b1; tick();
    bus_rd(2, d); chk("R6 rise ignored", d, 0);
    bus_wr(5, 0);

    // R7 writable sense bits
    bus_wr(5, '1);
    bus_rd(5, d); chk("R7 sense mask", d, 32'hffff7f00);
    bus_wr(5, 0);

    // R8 priority among 10 (lo b6), 40 (lo b23), 60 (hi b28)
    src_n[10] = 1'b0; src_n[40] = 1'b0; src_n[60] = 1'b0; tick();
    bus_wr(0, '1); bus_wr(1, '1);
    bus_rd(4, d); chk("R8 lowest wins", d, 32'd10 << 26);
    bus_wr(4, '1);
    bus_rd(4, d); chk("R8 vector write ignored", d, 32'd10 << 26);
    bus_wr(6, 32'h12345678); bus_wr(7, 32'ha5a5a5a5);
    bus_rd(6, d); chk("R10 prio hi rw", d, 32'h12345678);
    bus_rd(7, d); chk("R10 prio lo rw", d, 32'ha5a5a5a5);
    bus_rd(4, d); chk("R10 no vector effect", d, 32'd10 << 26);
    bus_wr(1, ~(32'd1 << 6));
    bus_rd(4, d); chk("R8 next winner", d, 32'd40 << 26);
    bus_wr(1, 0);
    bus_rd(4, d); chk("R8 port winner", d, 32'd60 << 26);
    chk("R9 irq on", irq, 1);
    bus_wr(0, 0);
    bus_rd(4, d); chk("R8 idle vector", d, 0);
    chk("R9 irq off", irq, 0);
    src_n[10] = 1'b1; src_n[40] = 1'b1; src_n[60] = 1'b1; tick();
    bus_wr(2, '1);
    bus_rd(2, d); chk("R3 final hi", d, 0);
    bus_rd(3, d); chk("R4 final lo", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule